// File: doc/BRIEF.md
# Serial-to-Bus Register Bridge

This block lets a host reach memory-mapped registers through one asynchronous serial line. A serial receiver turns the line into bytes. A framing parser builds each command from those bytes: a command byte, a word count, a 32-bit address and, for writes, one 32-bit value per word. A Wishbone classic master then runs one bus cycle per word. For a read command, the parser hands each returned word to a serial transmitter, which sends it back to the host.

Characters use the usual 8N1 format. The line idles high. A character is a low start bit, eight data bits with the least significant bit first, and a high stop bit. `CLKS_PER_BIT` sets the bit period in clock cycles. For 115200 baud this is the clock frequency divided by 115200, which gives a bit time of about 8.68 us. The parser accepts no bytes while a bus cycle or a reply is in progress. The host must therefore leave enough time between words for a slave's acknowledge, which is normally only a few cycles.

Top module: `uwb_bridge_top`

## Requirements
- R1: Received characters are 8N1 with the least significant bit first. Each bit lasts `CLKS_PER_BIT` clocks, and each bit is sampled near its middle.
- R2: A low pulse that has returned high by the middle of the start bit is ignored, and no byte results from it.
- R3: A character whose stop bit is low is dropped. The receiver then waits for the line to return high before it looks for a new start bit.
- R4: The first byte of a frame is the command, where 0x01 is write. The second byte is the word count N. Then come four address bytes, most significant byte first. For a write, four data bytes per word follow, most significant byte first.
- R5: Each word produces one bus cycle. During the cycle, cyc and stb are high, sel is 4'b1111 and we is high for writes. Address, data and we stay stable until ack. After ack, cyc and stb are low for at least one clock.
- R6: When N > 1, the address of each word after the first is 4 more than that of the word before it.
- R7: Command 0x02 is read. It performs N bus cycles with we low. Each returned word is sent back as four 8N1 characters, most significant byte first.
- R8: A command byte other than 0x01 or 0x02 is discarded, and the byte after it is taken as a new command.
- R9: A count of 0 finishes the frame after the four address bytes. No bus cycle is made, and the parser then waits for a command.
- R10: While synchronous reset is high, cyc and stb are low and the transmit line is high. After reset, the parser waits for a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_rx_i | input | 1 | Serial input from the host |
| ser_tx_o | output | 1 | Serial reply to the host |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_sel_o | output | 4 | Byte selects |
| wb_adr_o | output | 32 | Byte address |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_ack_i | input | 1 | Slave acknowledge |

## Verification
The bench drives a start glitch and a character with a low stop bit into the middle of a frame. A receiver that accepted either one would shift every later address byte and write to the wrong place. Multi-word writes and reads confirm the address step of 4 and the byte order in both directions; a design that got either wrong would report mismatched addresses or swapped bytes. An unknown command, a zero count and a reset in mid-frame each come just before a normal frame. A parser that kept stale state would misread that following frame.

// File: rtl/uwb_pkg.sv
package uwb_pkg;
    localparam logic [7:0] OP_WRITE = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h02;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_BREAK
    } rx_state_t;

    typedef enum logic [2:0] {
        P_CMD, P_LEN, P_ADR, P_DAT, P_BUS, P_SEND, P_NEXT
    } pstate_t;
endpackage

// File: rtl/uwb_uart_rx.sv
module uwb_uart_rx
    import uwb_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    output logic [7:0] byte_o,
    output logic       valid_o
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] MID  = CW'(CLKS_PER_BIT / 2 - 1);

    typedef struct packed {
        rx_state_t   st;
        logic [CW-1:0] cnt;
        logic [2:0]  bitn;
        logic [7:0]  sh;
        logic [1:0]  sync;
        logic        valid;
        logic [7:0]  data;
    } rx_regs_t;

    rx_regs_t q, d;
    logic     rxd;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.sync  = {q.sync[0], line_i};
        rxd     = q.sync[1];
        case (q.st)
            RX_IDLE: if (!rxd) begin
                d.st  = RX_START;
                d.cnt = '0;
            end
            RX_START: if (q.cnt == MID) begin
                d.cnt  = '0;
                d.bitn = '0;
                d.st   = rxd ? RX_IDLE : RX_BITS;
            end else d.cnt = q.cnt + 1'b1;
            RX_BITS: if (q.cnt == LAST) begin
                d.cnt = '0;
                d.sh  = {rxd, q.sh[7:1]};
                if (q.bitn == 3'd7) d.st = RX_STOP;
                else d.bitn = q.bitn + 1'b1;
            end else d.cnt = q.cnt + 1'b1;
            RX_STOP: if (q.cnt == LAST) begin
                d.cnt = '0;
                if (rxd) begin
                    d.valid = 1'b1;
                    d.data  = q.sh;
                    d.st    = RX_IDLE;
                end else d.st = RX_BREAK;
            end else d.cnt = q.cnt + 1'b1;
            RX_BREAK: if (rxd) d.st = RX_IDLE;
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            q.st   <= RX_IDLE;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign byte_o  = q.data;
    assign valid_o = q.valid;

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o) else $error("rx valid longer than one cycle"); // R1
    AST_RX_BREAK_SILENT: assert property (@(posedge clk) disable iff (rst)
        (q.st == RX_BREAK) |=> !valid_o) else $error("byte after framing error"); // R3
endmodule

// File: rtl/uwb_uart_tx.sv
module uwb_uart_tx #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic [7:0] byte_i,
    output logic       line_o,
    output logic       busy_o
);
    localparam int CW = $clog2(CLKS_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [3:0]    bitn;
        logic [9:0]    sh;
    } tx_regs_t;

    tx_regs_t q, d;

    always_comb begin
        d = q;
        if (!q.busy) begin
            if (go_i) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, byte_i, 1'b0};
                d.cnt  = '0;
                d.bitn = '0;
            end
        end else if (q.cnt == LAST) begin
            d.cnt = '0;
            d.sh  = {1'b1, q.sh[9:1]};
            if (q.bitn == 4'd9) d.busy = 1'b0;
            else d.bitn = q.bitn + 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.sh <= '1;
        end else begin
            q <= d;
        end
    end

    assign line_o = q.busy ? q.sh[0] : 1'b1;
    assign busy_o = q.busy;

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> !line_o) else $error("no start bit"); // R7
    AST_TX_GO_IDLE: assert property (@(posedge clk) disable iff (rst)
        go_i |-> !busy_o) else $error("go while busy"); // R7
endmodule

// File: rtl/uwb_cmd_engine.sv
module uwb_cmd_engine
    import uwb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  rx_byte_i,
    input  logic        rx_valid_i,
    input  logic        tx_busy_i,
    output logic        tx_go_o,
    output logic [7:0]  tx_byte_o,
    output logic        wb_cyc_o,
    output logic        wb_stb_o,
    output logic        wb_we_o,
    output logic [3:0]  wb_sel_o,
    output logic [31:0] wb_adr_o,
    output logic [31:0] wb_dat_o,
    input  logic [31:0] wb_dat_i,
    input  logic        wb_ack_i
);
    typedef struct packed {
        pstate_t     st;
        logic        is_rd;
        logic [7:0]  words;
        logic [1:0]  bcnt;
        logic [31:0] adr;
        logic [31:0] dat;
        logic        go;
        logic [7:0]  txb;
    } eng_regs_t;

    eng_regs_t q, d;

    always_comb begin
        d    = q;
        d.go = 1'b0;
        case (q.st)
            P_CMD: if (rx_valid_i) begin
                if (rx_byte_i == OP_WRITE || rx_byte_i == OP_READ) begin
                    d.is_rd = (rx_byte_i == OP_READ);
                    d.st    = P_LEN;
                end
            end
            P_LEN: if (rx_valid_i) begin
                d.words = rx_byte_i;
                d.bcnt  = '0;
                d.st    = P_ADR;
            end
            P_ADR: if (rx_valid_i) begin
                d.adr = {q.adr[23:0], rx_byte_i};
                if (q.bcnt == 2'd3) begin
                    d.bcnt = '0;
                    if (q.words == 8'd0) d.st = P_CMD;
                    else d.st = q.is_rd ? P_BUS : P_DAT;
                end else d.bcnt = q.bcnt + 1'b1;
            end
            P_DAT: if (rx_valid_i) begin
                d.dat = {q.dat[23:0], rx_byte_i};
                if (q.bcnt == 2'd3) begin
                    d.bcnt = '0;
                    d.st   = P_BUS;
                end else d.bcnt = q.bcnt + 1'b1;
            end
            P_BUS: if (wb_ack_i) begin
                if (q.is_rd) begin
                    d.dat  = wb_dat_i;
                    d.bcnt = '0;
                    d.st   = P_SEND;
                end else d.st = P_NEXT;
            end
            P_SEND: if (!tx_busy_i && !q.go) begin
                d.go  = 1'b1;
                d.txb = q.dat[31:24];
                d.dat = {q.dat[23:0], 8'h00};
                if (q.bcnt == 2'd3) begin
                    d.bcnt = '0;
                    d.st   = P_NEXT;
                end else d.bcnt = q.bcnt + 1'b1;
            end
            P_NEXT: begin
                d.words = q.words - 1'b1;
                d.adr   = q.adr + 32'd4;
                d.bcnt  = '0;
                if (q.words == 8'd1) d.st = P_CMD;
                else d.st = q.is_rd ? P_BUS : P_DAT;
            end
            default: d.st = P_CMD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= P_CMD;
        end else begin
            q <= d;
        end
    end

    assign wb_cyc_o  = (q.st == P_BUS);
    assign wb_stb_o  = (q.st == P_BUS);
    assign wb_we_o   = !q.is_rd;
    assign wb_sel_o  = 4'hF;
    assign wb_adr_o  = q.adr;
    assign wb_dat_o  = q.dat;
    assign tx_go_o   = q.go;
    assign tx_byte_o = q.txb;

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && wb_stb_o && $stable(wb_adr_o)
                                      && $stable(wb_dat_o) && $stable(wb_we_o)))
        else $error("bus request changed before ack"); // R5
    AST_BUS_GAP: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && wb_ack_i) |=> !wb_cyc_o) else $error("no idle cycle after ack"); // R5
    AST_SEND_NOT_BUS: assert property (@(posedge clk) disable iff (rst)
        tx_go_o |-> !tx_busy_i) else $error("byte handed to busy transmitter"); // R7
endmodule

// File: rtl/uwb_bridge_top.sv
module uwb_bridge_top #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_rx_i,
    output logic        ser_tx_o,
    output logic        wb_cyc_o,
    output logic        wb_stb_o,
    output logic        wb_we_o,
    output logic [3:0]  wb_sel_o,
    output logic [31:0] wb_adr_o,
    output logic [31:0] wb_dat_o,
    input  logic [31:0] wb_dat_i,
    input  logic        wb_ack_i
);
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       tx_go;
    logic [7:0] tx_byte;
    logic       tx_busy;

    uwb_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rx_i (
        .clk(clk), .rst(rst), .line_i(ser_rx_i),
        .byte_o(rx_byte), .valid_o(rx_valid)
    );

    uwb_cmd_engine eng_i (
        .clk(clk), .rst(rst),
        .rx_byte_i(rx_byte), .rx_valid_i(rx_valid),
        .tx_busy_i(tx_busy), .tx_go_o(tx_go), .tx_byte_o(tx_byte),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_sel_o(wb_sel_o), .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o),
        .wb_dat_i(wb_dat_i), .wb_ack_i(wb_ack_i)
    );

    uwb_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
        .clk(clk), .rst(rst), .go_i(tx_go), .byte_i(tx_byte),
        .line_o(ser_tx_o), .busy_o(tx_busy)
    );
endmodule

// File: tb/uwb_bridge_top_tb.sv
module uwb_bridge_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPB = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_rx = 1'b1;
    logic        ser_tx;
    logic        cyc, stb, we;
    logic [3:0]  sel;
    logic [31:0] adr, dat_o;
    logic [31:0] dat_i = '0;
    logic        ack = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    uwb_bridge_top #(.CLKS_PER_BIT(CPB)) dut_i (
        .clk(clk), .rst(rst), .ser_rx_i(ser_rx), .ser_tx_o(ser_tx),
        .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_sel_o(sel),
        .wb_adr_o(adr), .wb_dat_o(dat_o), .wb_dat_i(dat_i), .wb_ack_i(ack)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] rd_val(input logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
    endfunction

    // bus slave model with random acknowledge delay and a log of cycles
    logic [31:0] log_adr [0:255];
    logic [31:0] log_dat [0:255];
    logic        log_we  [0:255];
    logic [3:0]  log_sel [0:255];
    int n_log = 0;
    int dly = 0;

    always @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            dly <= 0;
        end else if (ack) begin
            ack <= 1'b0;
        end else if (cyc && stb) begin
            if (dly == 0) begin
                ack   <= 1'b1;
                dat_i <= rd_val(adr);
                if (n_log < 256) begin
                    log_adr[n_log] = adr;
                    log_dat[n_log] = dat_o;
                    log_we[n_log]  = we;
                    log_sel[n_log] = sel;
                end
                n_log = n_log + 1;
                dly   <= int'($urandom % 4);
            end else begin
                dly <= dly - 1;
            end
        end
    end

    // serial reply monitor
    logic [7:0] rxq [0:63];
    int n_rxq = 0;
    always begin
        @(negedge ser_tx);
        if (!rst) begin
            logic [7:0] b;
            repeat (CPB / 2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
                repeat (CPB) @(negedge clk);
                b[i] = ser_tx;
            end
            repeat (CPB) @(negedge clk);
            if (n_rxq < 64) rxq[n_rxq] = b;
            n_rxq = n_rxq + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        @(negedge clk);
        ser_rx = v;
        repeat (CPB - 1) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_ok = 1'b1);
        bit_time(1'b0);
        for (int i = 0; i < 8; i++) bit_time(b[i]);
        bit_time(stop_ok);
        if (!stop_ok) begin
            bit_time(1'b1);
            bit_time(1'b1);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) send_byte(w[8*i +: 8]);
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] wd [0:7];

    task automatic write_frame(input logic [31:0] a, input int n, input string req);
        int base;
        base = n_log;
        send_byte(8'h01);
        send_byte(8'(n));
        send_word(a);
        for (int k = 0; k < n; k++) send_word(wd[k]);
        idle_wait(40);
        chk(n_log == base + n, req, 32'(n_log - base), 32'(n));
        for (int k = 0; k < n && base + k < n_log; k++) begin
            chk(log_adr[base+k] == a + 32'(4*k), "R6 address", log_adr[base+k], a + 32'(4*k));
            chk(log_dat[base+k] == wd[k], "R4 data", log_dat[base+k], wd[k]);
            chk(log_we[base+k] == 1'b1 && log_sel[base+k] == 4'hF, "R5 we/sel",
                {27'd0, log_we[base+k], log_sel[base+k]}, 32'h1F);
        end
    endtask

    initial begin
        logic [31:0] a;
        int n, base, rbase, tmo;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(cyc == 1'b0 && stb == 1'b0, "R10 reset strobes", {31'd0, cyc}, 0);
        chk(ser_tx == 1'b1, "R10 reset tx idle", {31'd0, ser_tx}, 1);
        rst = 1'b0;
        idle_wait(20);

        // directed single write (R4, R5)
        wd[0] = 32'hFACE2BED;
        write_frame(32'hFEEDBACC, 1, "R4 single write count");

        // random multi-word writes (R1, R6)
        for (int t = 0; t < 6; t++) begin
            n = 1 + int'($urandom % 3);
            for (int k = 0; k < n; k++) wd[k] = $urandom;
            write_frame({$urandom} & 32'hFFFF_FFFC, n, "R1 random write count");
        end

        // read of two words (R7)
        base  = n_log;
        rbase = n_rxq;
        a = 32'h1234_5670;
        send_byte(8'h02);
        send_byte(8'h02);
        send_word(a);
        tmo = 0;
        while (n_rxq < rbase + 8 && tmo < 20000) begin
            @(negedge clk);
            tmo++;
        end
        idle_wait(4 * CPB);
        chk(n_log == base + 2, "R7 read cycle count", 32'(n_log - base), 2);
        chk(n_rxq == rbase + 8, "R7 reply byte count", 32'(n_rxq - rbase), 8);
        for (int k = 0; k < 2; k++) begin
            logic [31:0] got;
            if (base + k < n_log)
                chk(log_we[base+k] == 1'b0 && log_adr[base+k] == a + 32'(4*k),
                    "R7 read cycle", log_adr[base+k], a + 32'(4*k));
            got = {rxq[rbase+4*k], rxq[rbase+4*k+1], rxq[rbase+4*k+2], rxq[rbase+4*k+3]};
            chk(got == rd_val(a + 32'(4*k)), "R7 reply data", got, rd_val(a + 32'(4*k)));
        end

        // unknown command discarded (R8)
        send_byte(8'h7E);
        wd[0] = 32'h0BAD_F00D;
        write_frame(32'h0000_0040, 1, "R8 after unknown command");

        // start glitch inside a frame (R2)
        base = n_log;
        send_byte(8'h01);
        send_byte(8'h01);
        @(negedge clk) ser_rx = 1'b0;
        repeat (CPB / 4) @(negedge clk);
        ser_rx = 1'b1;
        idle_wait(3 * CPB);
        send_word(32'hA0A0_0100);
        send_word(32'h1357_9BDF);
        idle_wait(40);
        chk(n_log == base + 1, "R2 glitch count", 32'(n_log - base), 1);
        if (n_log > base)
            chk(log_adr[base] == 32'hA0A0_0100, "R2 glitch address", log_adr[base], 32'hA0A0_0100);

        // framing error inside a frame (R3)
        base = n_log;
        send_byte(8'h01);
        send_byte(8'h01);
        send_byte(8'h33, 1'b0);
        send_word(32'hB0B0_0200);
        send_word(32'h2468_ACE0);
        idle_wait(40);
        chk(n_log == base + 1, "R3 framing count", 32'(n_log - base), 1);
        if (n_log > base)
            chk(log_adr[base] == 32'hB0B0_0200, "R3 framing address", log_adr[base], 32'hB0B0_0200);

        // zero count (R9)
        base = n_log;
        send_byte(8'h01);
        send_byte(8'h00);
        send_word(32'hC0C0_0300);
        idle_wait(40);
        chk(n_log == base, "R9 zero count no cycle", 32'(n_log - base), 0);
        wd[0] = 32'h7777_1111;
        write_frame(32'hC0C0_0304, 1, "R9 frame after zero count");

        // reset in the middle of a frame (R10)
        send_byte(8'h01);
        send_byte(8'h01);
        send_byte(8'hAA);
        send_byte(8'hBB);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cyc == 1'b0 && ser_tx == 1'b1, "R10 mid-frame reset", {30'd0, cyc, ser_tx}, 1);
        rst = 1'b0;
        idle_wait(10);
        wd[0] = 32'h5555_AAAA;
        write_frame(32'hD0D0_0400, 1, "R10 frame after reset");

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule